// File: doc/BRIEF.md
# Self-Timed Burst Serial Receiver

This block receives asynchronous serial characters without a configured bit rate. It sleeps with its wake output low until the synchronized receive line falls. That falling edge raises the wake output, which can enable a local timing source. The first character of every burst must be the alternating pattern 0x55. The block times that character, derives the bit period in sample clocks, and reports the result as the divisor output.

With the divisor locked, each later character is timed from its own start-bit falling edge. The start bit is confirmed at half a bit period, and each bit after it is sampled one divisor later. Frames are one start bit, eight data bits sent least significant first, and one stop bit. Good characters appear on a byte output with a one-cycle strobe.

A burst ends when the configured stop character arrives or when a configured number of bytes has been delivered. The block then drops lock and wake and sleeps until the next falling edge. A bad measurement also returns it to sleep and raises a one-cycle sync-error pulse.

Top module: `abr_rx`

## Requirements
- R1: After reset, awake, locked, byte_valid, frame_err and sync_err are 0 and divisor is 0.
- R2: A falling edge on rx_serial while asleep sets awake to 1 within four clock cycles of the line going low. The line passes through a two-flop synchronizer first.
- R3: The divisor is the number of sample clocks from the start-bit falling edge of the sync character to its fourth following falling edge, divided by 8 and rounded down. For a bit period of T clocks this gives T.
- R4: Locked rises once the divisor has been captured. The sync character 0x55 is never presented on byte_out.
- R5: Data bits are sampled at half a divisor after the start edge plus one divisor per bit, least significant bit first. Each good character raises byte_valid for one cycle with the byte on byte_out.
- R6: If the line is high again at the half-divisor check of the start bit, the edge is ignored. No byte and no error result, and locked stays 1.
- R7: A low stop bit gives a one-cycle frame_err pulse with no byte_valid, and the burst continues.
- R8: Delivering a byte equal to stop_char ends the burst: locked and awake return to 0.
- R9: When max_count is nonzero, the burst ends right after the max_count-th delivered byte. A max_count of 0 sets no count limit.
- R10: A measured divisor below 4 gives a one-cycle sync_err pulse and a return to sleep, with locked and awake at 0.
- R11: If the measurement counter reaches its maximum before the fourth falling edge, sync_err is pulsed and the block returns to sleep.
- R12: Every burst measures its divisor anew, and the divisor does not change while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_serial | input | 1 | Serial receive line, idle high, asynchronous to clk |
| stop_char | input | 8 | Byte value that ends a burst |
| max_count | input | CNT_W (8) | Delivered-byte limit per burst, 0 for no limit |
| byte_out | output | 8 | Last received character |
| byte_valid | output | 1 | One-cycle strobe for byte_out |
| divisor | output | CW-3 (13) | Measured bit period in sample clocks |
| locked | output | 1 | Divisor captured; burst in progress |
| awake | output | 1 | Enable for the local timing source |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |
| sync_err | output | 1 | One-cycle pulse on a bad measurement |

## Verification
The assertions assume the divisor stays fixed for the length of each frame and that the line stays idle high between characters. The stop check then lands inside the stop bit. The bench holds every bit for a whole number of clocks, at least four for a good lock, and returns the line high after each frame before the next start edge. Glitches are kept shorter than half a bit period. Only the overflow test holds the line low for longer than the counter can measure.

// File: rtl/abr_pkg.sv
// Shared types for the burst receiver.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package abr_pkg;

    // Burst-level states: sleeping, timing the sync character, waiting for a start edge, in a frame.
    typedef enum logic [1:0] {
        BS_SLEEP   = 2'd0,
        BS_MEASURE = 2'd1,
        BS_READY   = 2'd2,
        BS_FRAME   = 2'd3
    } burst_state_t;

    // Character-level states inside one frame.
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_START = 2'd1,
        FS_DATA  = 2'd2,
        FS_STOP  = 2'd3
    } frame_state_t;

    // Data bits per character.
    localparam int unsigned DATA_BITS = 8;

endpackage

// File: rtl/abr_sync.sv
// Two-flop synchronizer plus falling-edge detector for the serial line.
// Assumes: the line idles high, so all stages reset to 1.
module abr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic line,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Resample the asynchronous line and keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Present the synchronized level and a one-cycle high-to-low flag.
    assign line = sync_q;
    assign fall = prev_q & ~sync_q;

endmodule

// File: rtl/abr_meas.sv
// Bit-period measurement on the sync character 0x55.
// Counts clocks from the start edge (arm) to the fourth later falling edge, which spans
// eight bit periods, and returns that count divided by 8.
// Assumes: arm and run are never high together; run stays high until done or bad.
module abr_meas #(
    parameter int unsigned CW      = 16,
    parameter int unsigned MIN_DIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          run,
    input  logic          fall,
    output logic          done,
    output logic          bad,
    output logic [CW-4:0] div_q
);

    localparam int unsigned DIV_W = CW - 3;
    localparam logic [DIV_W-1:0] MIN_Q = DIV_W'(MIN_DIV);

    logic [CW-1:0] mcnt;
    logic [1:0]    ecnt;
    logic          fin;

    // Elapsed-clock counter, falling-edge counter and one-shot result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcnt  <= '0;
            ecnt  <= '0;
            fin   <= 1'b0;
            done  <= 1'b0;
            bad   <= 1'b0;
            div_q <= '0;
        end else begin
            done <= 1'b0;
            bad  <= 1'b0;
            if (arm) begin
                mcnt <= CW'(1);
                ecnt <= '0;
                fin  <= 1'b0;
            end else if (run && !fin) begin
                if (fall && ecnt == 2'd3) begin
                    fin <= 1'b1;
                    if (mcnt[CW-1:3] < MIN_Q) begin
                        bad <= 1'b1;
                    end else begin
                        done  <= 1'b1;
                        div_q <= mcnt[CW-1:3];
                    end
                end else begin
                    if (fall) begin
                        ecnt <= ecnt + 2'd1;
                    end
                    if (mcnt == '1) begin
                        fin <= 1'b1;
                        bad <= 1'b1;
                    end else begin
                        mcnt <= mcnt + CW'(1);
                    end
                end
            end
        end
    end

    AST_MEAS_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && bad)); // R10
    AST_DIV_AT_LEAST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_q >= MIN_Q)); // R3

endmodule

// File: rtl/abr_frame.sv
// One-character receiver timed from the start edge using the locked divisor.
// Confirms the start bit at div/2, samples eight data bits LSB first at div spacing,
// then checks the stop bit.
// Assumes: div >= 4 and div held stable while a frame is in progress.
module abr_frame
    import abr_pkg::*;
#(
    parameter int unsigned DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIV_W-1:0] div,
    input  logic             line,
    output logic             vld,
    output logic             ferr,
    output logic             fin,
    output logic [7:0]       data
);

    localparam int unsigned IDX_W = $clog2(DATA_BITS);

    frame_state_t     fst;
    logic [DIV_W-1:0] tcnt;
    logic [DIV_W-1:0] half;
    logic [IDX_W-1:0] idx;
    logic [7:0]       shreg;

    // Half-period point used for the start-bit confirmation.
    assign half = div >> 1;

    // Frame sequencer: start check, data shift, stop check, result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst   <= FS_IDLE;
            tcnt  <= '0;
            idx   <= '0;
            shreg <= '0;
            vld   <= 1'b0;
            ferr  <= 1'b0;
            fin   <= 1'b0;
            data  <= '0;
        end else begin
            vld  <= 1'b0;
            ferr <= 1'b0;
            fin  <= 1'b0;
            case (fst)
                FS_IDLE: begin
                    if (go) begin
                        fst  <= FS_START;
                        tcnt <= DIV_W'(1);
                    end
                end
                FS_START: begin
                    if (tcnt == half) begin
                        if (line) begin
                            fst <= FS_IDLE;
                            fin <= 1'b1;
                        end else begin
                            fst  <= FS_DATA;
                            tcnt <= DIV_W'(1);
                            idx  <= '0;
                        end
                    end else begin
                        tcnt <= tcnt + DIV_W'(1);
                    end
                end
                FS_DATA: begin
                    if (tcnt == div) begin
                        shreg <= {line, shreg[7:1]};
                        tcnt  <= DIV_W'(1);
                        idx   <= idx + IDX_W'(1);
                        if (idx == IDX_W'(DATA_BITS - 1)) begin
                            fst <= FS_STOP;
                        end
                    end else begin
                        tcnt <= tcnt + DIV_W'(1);
                    end
                end
                FS_STOP: begin
                    if (tcnt == div) begin
                        fst <= FS_IDLE;
                        fin <= 1'b1;
                        if (line) begin
                            vld  <= 1'b1;
                            data <= shreg;
                        end else begin
                            ferr <= 1'b1;
                        end
                    end else begin
                        tcnt <= tcnt + DIV_W'(1);
                    end
                end
                default: fst <= FS_IDLE;
            endcase
        end
    end

    AST_FRAME_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld && ferr)); // R7
    AST_RESULT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (vld || ferr) |-> fin); // R5
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (fst != FS_IDLE) |-> (tcnt <= div)); // R5

endmodule

// File: rtl/abr_rx.sv
// Burst receiver top: wakes on a falling edge, measures the divisor from the sync
// character, receives characters until the stop character or byte limit, then sleeps.
// Assumes: rx_serial idles high; stop_char and max_count are stable during a burst.
module abr_rx
    import abr_pkg::*;
#(
    parameter int unsigned CW      = 16,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_serial,
    input  logic [7:0]       stop_char,
    input  logic [CNT_W-1:0] max_count,
    output logic [7:0]       byte_out,
    output logic             byte_valid,
    output logic [CW-4:0]    divisor,
    output logic             locked,
    output logic             awake,
    output logic             frame_err,
    output logic             sync_err
);

    localparam int unsigned DIV_W = CW - 3;

    burst_state_t     bst;
    logic             line;
    logic             fall;
    logic             arm;
    logic             run;
    logic             go;
    logic             m_done;
    logic             m_bad;
    logic [DIV_W-1:0] m_div;
    logic             f_vld;
    logic             f_ferr;
    logic             f_fin;
    logic [7:0]       f_data;
    logic [CNT_W-1:0] bcnt;
    logic             burst_end;

    abr_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_serial),
        .line     (line),
        .fall     (fall)
    );

    // Steering of the shared falling-edge flag by burst state.
    assign arm = (bst == BS_SLEEP) && fall;
    assign run = (bst == BS_MEASURE);
    assign go  = (bst == BS_READY) && fall;

    abr_meas #(
        .CW      (CW),
        .MIN_DIV (MIN_DIV)
    ) u_meas (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .run   (run),
        .fall  (fall),
        .done  (m_done),
        .bad   (m_bad),
        .div_q (m_div)
    );

    abr_frame #(
        .DIV_W (DIV_W)
    ) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .div   (m_div),
        .line  (line),
        .vld   (f_vld),
        .ferr  (f_ferr),
        .fin   (f_fin),
        .data  (f_data)
    );

    // A delivered byte ends the burst on a stop-character match or on reaching the limit.
    assign burst_end = f_vld &&
                       ((f_data == stop_char) ||
                        ((max_count != '0) && (bcnt + CNT_W'(1) == max_count)));

    // Burst sequencer and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst  <= BS_SLEEP;
            bcnt <= '0;
        end else begin
            case (bst)
                BS_SLEEP: begin
                    if (fall) begin
                        bst  <= BS_MEASURE;
                        bcnt <= '0;
                    end
                end
                BS_MEASURE: begin
                    if (m_bad) begin
                        bst <= BS_SLEEP;
                    end else if (m_done) begin
                        bst <= BS_READY;
                    end
                end
                BS_READY: begin
                    if (fall) begin
                        bst <= BS_FRAME;
                    end
                end
                BS_FRAME: begin
                    if (f_fin) begin
                        bst <= burst_end ? BS_SLEEP : BS_READY;
                    end
                    if (f_vld) begin
                        bcnt <= bcnt + CNT_W'(1);
                    end
                end
                default: bst <= BS_SLEEP;
            endcase
        end
    end

    // Registered result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out   <= '0;
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            sync_err   <= 1'b0;
        end else begin
            byte_valid <= f_vld;
            frame_err  <= f_ferr;
            sync_err   <= m_bad;
            if (f_vld) begin
                byte_out <= f_data;
            end
        end
    end

    assign divisor = m_div;
    assign awake   = (bst != BS_SLEEP);
    assign locked  = (bst == BS_READY) || (bst == BS_FRAME);

    AST_WAKE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake) |-> $past(fall)); // R2
    AST_LOCK_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> awake); // R8
    AST_BYTE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(locked)); // R4
    AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(divisor)); // R12
    AST_SYNC_ERR_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> (!awake && !locked)); // R10
    AST_LOCK_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (divisor >= DIV_W'(MIN_DIV))); // R3

endmodule

// File: tb/abr_rx_bench.sv
// Self-checking bench: a vector table of bursts followed by directed corner tests.
module abr_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int WATCHDOG   = 190000;
    localparam logic [7:0] STOPC = 8'h0D;
    localparam int NVEC = 6;
    // Each entry: {bit period in clocks, data byte}.
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd4,  8'hA3}, {8'd8,  8'h00}, {8'd16, 8'hFF},
        {8'd12, 8'h5A}, {8'd37, 8'h81}, {8'd5,  8'h3C}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx = 1'b1;
    logic [7:0]       stop_char = STOPC;
    logic [CNT_W-1:0] max_count = '0;
    logic [7:0]       byte_out;
    logic             byte_valid;
    logic [12:0]      divisor;
    logic             locked;
    logic             awake;
    logic             frame_err;
    logic             sync_err;

    int nchk = 0;
    int nfail = 0;
    int nrx = 0;
    int nfe = 0;
    int nse = 0;
    logic [7:0] rxq [64];
    bit finished = 1'b0;

    abr_rx u_abr_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_serial  (rx),
        .stop_char  (stop_char),
        .max_count  (max_count),
        .byte_out   (byte_out),
        .byte_valid (byte_valid),
        .divisor    (divisor),
        .locked     (locked),
        .awake      (awake),
        .frame_err  (frame_err),
        .sync_err   (sync_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                rxq[nrx % 64] = byte_out;
                nrx++;
            end
            if (frame_err) nfe++;
            if (sync_err)  nse++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Data bits, stop bit and one idle bit, after the start bit has been driven.
    task automatic send_tail(input logic [7:0] b, input int t, input logic stop_lvl);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            tick(t);
        end
        rx = stop_lvl;
        tick(t);
        rx = 1'b1;
        tick(t);
    endtask

    task automatic send_byte(input logic [7:0] b, input int t, input logic stop_lvl);
        rx = 1'b0;
        tick(t);
        send_tail(b, t, stop_lvl);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 awake", awake, 0);
        chk("R1 locked", locked, 0);
        chk("R1 byte_valid", byte_valid, 0);
        chk("R1 frame_err", frame_err, 0);
        chk("R1 sync_err", sync_err, 0);
        chk("R1 divisor", divisor, 0);

        // Vector table: sync, data, stop character per burst.
        for (int v = 0; v < NVEC; v++) begin
            int t;
            logic [7:0] d;
            t = int'(VEC[v][15:8]);
            d = VEC[v][7:0];
            base = nrx;
            send_byte(8'h55, t, 1'b1);
            chk("R3 divisor", divisor, t);
            chk("R4 locked", locked, 1);
            chk("R4 sync not delivered", nrx - base, 0);
            send_byte(d, t, 1'b1);
            chk("R12 divisor held", divisor, t);
            send_byte(STOPC, t, 1'b1);
            tick(4);
            chk("R5 byte count", nrx - base, 2);
            chk("R5 data byte", rxq[base % 64], d);
            chk("R8 stop char delivered", rxq[(base + 1) % 64], STOPC);
            chk("R8 awake after stop", awake, 0);
            chk("R8 locked after stop", locked, 0);
        end

        // R2 wake latency, then the rest of a sync character at T=20.
        rx = 1'b0;
        tick(4);
        chk("R2 awake", awake, 1);
        tick(16);
        send_tail(8'h55, 20, 1'b1);
        chk("R3 divisor T20", divisor, 20);

        // R6 glitch shorter than half a bit.
        base = nrx;
        begin
            int fe0;
            fe0 = nfe;
            rx = 1'b0;
            tick(3);
            rx = 1'b1;
            tick(60);
            chk("R6 no byte", nrx - base, 0);
            chk("R6 no frame error", nfe - fe0, 0);
            chk("R6 still locked", locked, 1);

            // R7 low stop bit.
            send_byte(8'h47, 20, 1'b0);
            tick(4);
            chk("R7 frame_err pulse", nfe - fe0, 1);
            chk("R7 no byte", nrx - base, 0);
            chk("R7 still locked", locked, 1);
        end
        send_byte(8'h6E, 20, 1'b1);
        send_byte(STOPC, 20, 1'b1);
        tick(4);
        chk("R5 byte after glitch", rxq[base % 64], 8'h6E);
        chk("R8 asleep", awake, 0);

        // R9 byte-count limit of 2.
        max_count = CNT_W'(2);
        base = nrx;
        send_byte(8'h55, 10, 1'b1);
        send_byte(8'h11, 10, 1'b1);
        chk("R9 awake before limit", awake, 1);
        send_byte(8'h22, 10, 1'b1);
        tick(4);
        chk("R9 bytes", nrx - base, 2);
        chk("R9 second byte", rxq[(base + 1) % 64], 8'h22);
        chk("R9 asleep", awake, 0);
        chk("R9 unlocked", locked, 0);
        max_count = '0;

        // R10 divisor below minimum.
        base = nse;
        send_byte(8'h55, 3, 1'b1);
        tick(4);
        chk("R10 sync_err", nse - base, 1);
        chk("R10 asleep", awake, 0);
        chk("R10 unlocked", locked, 0);

        // R11 measurement overflow on a stuck-low line.
        base = nse;
        rx = 1'b0;
        tick(70000);
        chk("R11 sync_err", nse - base, 1);
        chk("R11 asleep", awake, 0);
        rx = 1'b1;
        tick(20);

        // R12 a new burst measures again.
        send_byte(8'h55, 9, 1'b1);
        chk("R12 relock divisor", divisor, 9);
        send_byte(STOPC, 9, 1'b1);
        tick(4);
        chk("R12 asleep", awake, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule